// File: doc/BRIEF.md
# Four-Entry Fully Associative Tag Store with FIFO or LRU Replacement

This block records which addresses are currently resident in a small fully associative store and reports, for each presented access, whether it hit or missed. Any address may sit in any entry, and the whole address serves as the tag, because one entry covers exactly one address unit. On a miss the address is written into the store. Empty entries are used first. Once every entry is occupied, an existing entry is displaced.

A single mode input selects how the displaced entry is chosen. With `lru_mode` low the store runs in insertion order: the victim is the entry written earliest, and hits leave that order untouched. With `lru_mode` high it runs in recency order: the victim is the entry touched least recently, and every hit promotes the entry to most recent. Both policies share one order structure, so the same access stream can be replayed under each policy and the results compared. The mode may change between accesses. Two running counters total the hits and the misses.

The outcome is held in a small result state machine, updated on each clock edge. RS_IDLE means no access was presented in the previous cycle. RS_HIT means the address was found. RS_FILL means a miss that took an empty entry. RS_EVICT means a miss that displaced a valid entry. From any state the next state depends only on the current access: no access goes to RS_IDLE, a match goes to RS_HIT, a miss with a free entry goes to RS_FILL, and a miss with the store full goes to RS_EVICT.

Top module: `fac_cache`

## Requirements
- R1: An access hits exactly when its full `AW`-bit address equals the address of a valid entry. Addresses that differ in any bit are distinct.
- R2: The outcome of an access presented while `acc_valid` is high appears on `res_valid`/`res_hit`/`res_evict` in the following cycle. `res_valid` is low in the cycle after a cycle with `acc_valid` low.
- R3: Misses fill empty entries first, with `res_evict` low. `res_evict` goes high only on a miss that occurs after all `ENTRIES` entries are valid.
- R4: With `lru_mode`=0 (FIFO), a miss on a full store displaces the entry inserted earliest, and hits do not change that order.
- R5: With `lru_mode`=1 (LRU), a miss on a full store displaces the least recently accessed entry, and every hit makes the hit entry the most recent.
- R6: From an empty store in FIFO mode, the stream 0,1,2,3,0,4,1 gives miss, miss, miss, miss, hit, miss, hit.
- R7: From an empty store in LRU mode, the same stream gives miss, miss, miss, miss, hit, miss, miss.
- R8: `hit_count` rises by one with each reported hit and `miss_count` rises by one with each reported miss. Both change in the same cycle as the result and are otherwise stable.
- R9: Reset (`rst_n` low) empties every entry, clears the order state and zeroes both counters. After reset, `res_valid` is low.
- R10: The policy applies per access. A hit taken in FIFO mode leaves the order unchanged, and a later LRU-mode hit refreshes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | AW | Access address (full tag) |
| lru_mode | input | 1 | 1 = least-recently-used, 0 = insertion order |
| res_valid | output | 1 | Result of last cycle's access is present |
| res_hit | output | 1 | That access hit |
| res_evict | output | 1 | That access missed and displaced a valid entry |
| hit_count | output | CW | Total hits since reset |
| miss_count | output | CW | Total misses since reset |

## Verification
The bench builds the block with its defaults: four entries, 8-bit addresses and 16-bit counters. With only four entries, a pool of eight addresses forces frequent evictions while still allowing repeated hits. This lets the two fixed seven-access streams show the FIFO/LRU divergence exactly, and lets long random runs with mode toggles and idle gaps exercise both fill order and victim choice. An 8-bit address also allows addresses that differ only in the top bit, which checks that the whole address is compared.

// File: rtl/fac_pkg.sv
package fac_pkg;
    typedef enum logic [1:0] {
        RS_IDLE,
        RS_HIT,
        RS_FILL,
        RS_EVICT
    } res_state_e;
endpackage

// File: rtl/fac_match.sv
module fac_match #(
    parameter int AW      = 8,
    parameter int ENTRIES = 4
) (
    input  logic [ENTRIES-1:0][AW-1:0] tags,
    input  logic [ENTRIES-1:0]         valid,
    input  logic [AW-1:0]              addr,
    output logic [ENTRIES-1:0]         match
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == addr);
    end
endmodule

// File: rtl/fac_order.sv
// Rank per entry: 0 = most recently touched, ENTRIES-1 = next victim.
module fac_order #(
    parameter int ENTRIES = 4,
    parameter int RW      = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch,
    input  logic [RW-1:0] touch_idx,
    output logic [RW-1:0] oldest_idx
);
    localparam logic [RW-1:0] LAST_RANK = RW'(ENTRIES - 1);

    logic [ENTRIES-1:0][RW-1:0] rank_q;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_rank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rank_q[g] <= RW'(g);
            end else if (touch) begin
                if (touch_idx == RW'(g)) begin
                    rank_q[g] <= '0;
                end else if (rank_q[g] < rank_q[touch_idx]) begin
                    rank_q[g] <= rank_q[g] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        oldest_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (rank_q[i] == LAST_RANK) oldest_idx = RW'(i);
        end
    end
endmodule

// File: rtl/fac_counters.sv
module fac_counters #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_hit,
    input  logic          inc_miss,
    output logic [CW-1:0] hit_count,
    output logic [CW-1:0] miss_count
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_count  <= '0;
            miss_count <= '0;
        end else begin
            if (inc_hit)  hit_count  <= hit_count + 1'b1;
            if (inc_miss) miss_count <= miss_count + 1'b1;
        end
    end
endmodule

// File: rtl/fac_cache.sv
module fac_cache #(
    parameter int AW      = 8,
    parameter int ENTRIES = 4,
    parameter int CW      = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic [AW-1:0] acc_addr,
    input  logic          lru_mode,
    output logic          res_valid,
    output logic          res_hit,
    output logic          res_evict,
    output logic [CW-1:0] hit_count,
    output logic [CW-1:0] miss_count
);
    import fac_pkg::*;

    localparam int RW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0][AW-1:0] tag_q;
    logic [ENTRIES-1:0]         valid_q;
    logic [ENTRIES-1:0]         match_vec;
    logic [RW-1:0]              hit_idx;
    logic [RW-1:0]              free_idx;
    logic [RW-1:0]              oldest_idx;
    logic [RW-1:0]              ins_idx;
    logic                       any_hit;
    logic                       store_full;
    logic                       touch;
    res_state_e                 state_q, state_d;

    fac_match #(.AW(AW), .ENTRIES(ENTRIES)) u_match (
        .tags (tag_q),
        .valid(valid_q),
        .addr (acc_addr),
        .match(match_vec)
    );

    assign any_hit    = |match_vec;
    assign store_full = &valid_q;

    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) hit_idx  = RW'(i);
            if (!valid_q[i])  free_idx = RW'(i);
        end
    end

    assign ins_idx = store_full ? oldest_idx : free_idx;
    assign touch   = acc_valid && (!any_hit || lru_mode);

    fac_order #(.ENTRIES(ENTRIES), .RW(RW)) u_order (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch     (touch),
        .touch_idx (any_hit ? hit_idx : ins_idx),
        .oldest_idx(oldest_idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            tag_q   <= '0;
        end else if (acc_valid && !any_hit) begin
            valid_q[ins_idx] <= 1'b1;
            tag_q[ins_idx]   <= acc_addr;
        end
    end

    always_comb begin
        if (!acc_valid)      state_d = RS_IDLE;
        else if (any_hit)    state_d = RS_HIT;
        else if (store_full) state_d = RS_EVICT;
        else                 state_d = RS_FILL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        res_valid = 1'b0;
        res_hit   = 1'b0;
        res_evict = 1'b0;
        unique case (state_q)
            RS_IDLE:  ;
            RS_HIT:   begin res_valid = 1'b1; res_hit = 1'b1; end
            RS_FILL:  res_valid = 1'b1;
            RS_EVICT: begin res_valid = 1'b1; res_evict = 1'b1; end
        endcase
    end

    fac_counters #(.CW(CW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_hit   (state_d == RS_HIT),
        .inc_miss  (state_d == RS_FILL || state_d == RS_EVICT),
        .hit_count (hit_count),
        .miss_count(miss_count)
    );
endmodule

// File: rtl/fac_cache_chk.sv
module fac_cache_chk #(
    parameter int AW      = 8,
    parameter int ENTRIES = 4,
    parameter int CW      = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_valid,
    input logic [AW-1:0]      acc_addr,
    input logic               res_valid,
    input logic               res_hit,
    input logic               res_evict,
    input logic [CW-1:0]      hit_count,
    input logic [CW-1:0]      miss_count,
    input logic [ENTRIES-1:0] match_vec,
    input logic [ENTRIES-1:0] valid_q
);
    // R1: an address can be resident in at most one entry
    assert_single_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

    // R1: a repeated address in consecutive accesses must hit
    assert_repeat_hits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && $past(acc_valid) && $past(rst_n) && acc_addr == $past(acc_addr)) |=> res_hit);

    // R2: result follows the access by one cycle
    assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> res_valid);
    assert_no_result_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !res_valid);

    // R3: eviction only once the store is full
    assert_evict_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !(&valid_q)) |=> !res_evict);

    // R8: counters move together with results
    assert_hit_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_hit && $past(rst_n)) |-> hit_count == $past(hit_count) + 1'b1);
    assert_count_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_valid && $past(rst_n)) |-> ($stable(hit_count) && $stable(miss_count)));
    assert_miss_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit && $past(rst_n)) |-> miss_count == $past(miss_count) + 1'b1);
endmodule

bind fac_cache fac_cache_chk #(.AW(AW), .ENTRIES(ENTRIES), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_evict (res_evict),
    .hit_count (hit_count),
    .miss_count(miss_count),
    .match_vec (match_vec),
    .valid_q   (valid_q)
);

// File: tb/fac_cache_test.sv
module fac_cache_test;
    localparam int AW = 8;
    localparam int N  = 4;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic          lru_mode = 1'b0;
    logic          res_valid, res_hit, res_evict;
    logic [CW-1:0] hit_count, miss_count;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Reference model: residency in order, front = next victim
    int m_q[$];
    int m_hits, m_misses;
    bit e_valid, e_hit, e_evict;

    always #2 clk = ~clk;

    fac_cache #(.AW(AW), .ENTRIES(N), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .lru_mode(lru_mode), .res_valid(res_valid), .res_hit(res_hit),
        .res_evict(res_evict), .hit_count(hit_count), .miss_count(miss_count)
    );

    task automatic check(input string req, input bit ok, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void model_access(input bit v, input int a, input bit lru);
        int pos;
        e_valid = v; e_hit = 0; e_evict = 0;
        if (!v) return;
        pos = -1;
        foreach (m_q[i]) if (m_q[i] == a) pos = i;
        if (pos >= 0) begin
            e_hit = 1; m_hits++;
            if (lru) begin m_q.delete(pos); m_q.push_back(a); end
        end else begin
            m_misses++;
            if (m_q.size() == N) begin e_evict = 1; void'(m_q.pop_front()); end
            m_q.push_back(a);
        end
    endfunction

    task automatic compare(input string req);
        check(req, res_valid == e_valid, "res_valid", int'(res_valid), int'(e_valid));
        check(req, res_hit == e_hit, "res_hit", int'(res_hit), int'(e_hit));
        check(req, res_evict == e_evict, "res_evict", int'(res_evict), int'(e_evict));
        check("R8", hit_count == CW'(m_hits), "hit_count", int'(hit_count), m_hits);
        check("R8", miss_count == CW'(m_misses), "miss_count", int'(miss_count), m_misses);
    endtask

    task automatic step(input bit v, input int a, input bit lru, input string req);
        @(negedge clk);
        acc_valid = v; acc_addr = AW'(a); lru_mode = lru;
        model_access(v, a, lru);
        @(posedge clk); #1;
        compare(req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; acc_valid = 0;
        repeat (2) @(posedge clk);
        #1;
        m_q.delete(); m_hits = 0; m_misses = 0;
        e_valid = 0; e_hit = 0; e_evict = 0;
        @(negedge clk);
        rst_n = 1;
        compare("R9");
    endtask

    task automatic run_stream(input bit lru, input bit exp_hits[7], input string req);
        int s[7] = '{0, 1, 2, 3, 0, 4, 1};
        for (int i = 0; i < 7; i++) begin
            step(1, s[i], lru, req);
            check(req, res_hit == exp_hits[i], "stream hit", int'(res_hit), int'(exp_hits[i]));
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        bit fifo_exp[7] = '{0, 0, 0, 0, 1, 0, 1};
        bit lru_exp[7]  = '{0, 0, 0, 0, 1, 0, 0};
        do_reset();
        // R9: reset outputs are zero
        check("R9", hit_count == 0 && miss_count == 0, "counts after reset",
              int'(hit_count) + int'(miss_count), 0);

        // R6 / R4: insertion-order stream
        run_stream(0, fifo_exp, "R6");
        // R2: idle cycles produce no result
        step(0, 0, 0, "R2");
        step(0, 0, 0, "R2");

        // R9 then R7 / R5: recency stream from empty
        do_reset();
        run_stream(1, lru_exp, "R7");

        // R3: fill order and no eviction until full; R1: top-bit distinct addresses
        do_reset();
        step(1, 8'h05, 0, "R3");
        step(1, 8'h85, 0, "R1");
        step(1, 8'h05, 0, "R1");
        step(1, 8'h85, 0, "R1");
        step(1, 8'h06, 0, "R3");
        step(1, 8'h07, 0, "R3");
        check("R3", res_evict == 0, "evict before full", int'(res_evict), 0);
        step(1, 8'h08, 0, "R3");
        check("R3", res_evict == 1, "evict when full", int'(res_evict), 1);

        // R10: FIFO hit then LRU hit alter order differently
        do_reset();
        for (int i = 0; i < 4; i++) step(1, 16 + i, 0, "R4");
        step(1, 16, 0, "R10");   // FIFO hit: 16 stays oldest
        step(1, 20, 0, "R10");   // evicts 16
        step(1, 16, 1, "R10");   // miss, evicts 17
        step(1, 18, 1, "R10");   // LRU hit refreshes 18
        step(1, 21, 1, "R10");   // evicts 19
        step(1, 18, 1, "R10");   // still resident

        // Mixed random traffic, both policies, with gaps
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            bit v  = ($urandom_range(0, 9) != 0);
            bit m  = (i % 400) < 200 ? 1'b0 : ($urandom_range(0, 1) == 1);
            step(v, $urandom_range(0, 7) | (($urandom_range(0, 15) == 0) ? 8'h80 : 8'h00),
                 m, m ? "R5" : "R4");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule